// File: doc/BRIEF.md
# Configurable Generalized Parallel Counter Slice

This block is the first counting stage of one compressor slice. It sums up to sixteen input bits that sit in three adjacent columns: weight 1, weight 2 and weight 4. A configuration of three lengths chooses the split. The lowest `len0_i` data positions are weight-1 bits. The next `len1_i` positions are weight-2 bits. The next `len2_i` positions are weight-4 bits. Every position above these is ignored. The weighted population count is returned as a 5-bit unsigned value.

Two limits apply to a shape. It may use at most sixteen physical bits, and its largest possible weighted total may not exceed 31. A shape that breaks either limit, or a zero result width, is rejected. The block then raises an error flag and drives all of its outputs to zero.

A second stage formats the 6-bit result port in one of two ways. With the final adder in use, the port carries the low 1, 2 or 3 bits of the completed count. With the adder bypassed, the port carries the same number of bits twice, as a carry-save pair. The sum half is the weight-1 plus weight-2 contribution. The carry half is the weight-4 contribution. All outputs are registered one clock after the inputs are sampled.

Top module: `gpc_counter_slice`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `count_o`, `result_o` and `cfg_err_o` all at zero.
- R2: For a legal shape, `count_o` one cycle after sampling equals 1×(ones in data bits [len0-1:0]) + 2×(ones in bits [len0+len1-1:len0]) + 4×(ones in bits [len0+len1+len2-1:len0+len1]).
- R3: Data bits at positions at or above len0+len1+len2 have no effect on any output.
- R4: A shape is illegal when len0+len1+len2 > 16, when len0+2·len1+4·len2 > 31, or when `width_i` is 0. In that case `cfg_err_o` is 1 the next cycle and `count_o` and `result_o` are 0. Otherwise `cfg_err_o` is 0.
- R5: The shape len2=5, len1=4, len0=3 is legal, and with all twelve used bits set it yields `count_o` = 31.
- R6: With `bypass_i` = 0 and width w = `width_i` (1..3), `result_o[w-1:0]` equals `count_o` mod 2^w, and every other result bit is 0.
- R7: With `bypass_i` = 1 and width w, `result_o[w-1:0]` is (weight-1 total + weight-2 total) mod 2^w, and `result_o[w+2:3]` is the weight-4 total mod 2^w. All other result bits are 0.
- R8: `count_o` does not depend on `bypass_i` or on a nonzero `width_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_i | input | 16 | Data bits, packed by column from bit 0 |
| len0_i | input | 5 | Number of weight-1 bits |
| len1_i | input | 5 | Number of weight-2 bits |
| len2_i | input | 5 | Number of weight-4 bits |
| width_i | input | 2 | Result width per half, 1 to 3 bits |
| bypass_i | input | 1 | 1 selects carry-save output, 0 selects added output |
| count_o | output | 5 | Weighted population count |
| result_o | output | 6 | Formatted result: low half is sum or total, high half is carry |
| cfg_err_o | output | 1 | Shape or width illegal |

## Verification
The bench walks through every legal column split and drives random data each time, so bits beyond the configured span are usually set. A design that failed to mask those positions would overcount. A design with a wrong column boundary would weight bits incorrectly. Shapes that sit just past each limit (seventeen bits, a total of 32, a width of zero) are driven as well. A comparison off by one in the legality check would either let a bad shape produce numbers or reject a good one. The largest legal shape, run with all of its bits set, shows whether a 5-bit total is truncated. Toggling the bypass on fixed data shows whether the count is disturbed, and whether the weight-4 bits land in the carry half rather than the sum half.

// File: rtl/gpc_pkg.sv
// Package: shared sizes for the generalized parallel counter slice.
// Assumes three adjacent columns and a 5-bit weighted total.
package gpc_pkg;
    localparam int N_IN       = 16;               // physical data bits
    localparam int N_RANK     = 3;                // columns: weights 1,2,4
    localparam int KW         = $clog2(N_IN + 1); // length field width
    localparam int SW         = KW + 2;           // start offset width
    localparam int MAX_WEIGHT = 31;               // largest permitted total
    localparam int CNT_W      = $clog2(MAX_WEIGHT + 1);
    localparam int HALF_W     = 3;                // bits per result half
    localparam int RES_W      = 2 * HALF_W;
    localparam int WSEL_W     = 2;                // result width select
    localparam int BIG_W      = KW + N_RANK + 1;  // room for unchecked sums
endpackage

// File: rtl/gpc_cfg_check.sv
// Module: gpc_cfg_check
// Decides whether the requested column split is legal and derives the
// first data position of each column. Assumes column r has weight 2^r and
// that columns are packed upward from data bit 0 with no gaps.
module gpc_cfg_check
    import gpc_pkg::*;
#(
    parameter int P_N_IN   = N_IN,
    parameter int P_RANK   = N_RANK,
    parameter int P_KW     = KW,
    parameter int P_SW     = SW,
    parameter int P_BIG_W  = BIG_W,
    parameter int P_MAXW   = MAX_WEIGHT,
    parameter int P_WSEL_W = WSEL_W
) (
    input  logic [P_RANK-1:0][P_KW-1:0] len_i,
    input  logic [P_WSEL_W-1:0]         width_i,
    output logic [P_RANK-1:0][P_SW-1:0] start_o,
    output logic                        legal_o
);
    logic [P_BIG_W-1:0] bits_used;
    logic [P_BIG_W-1:0] weight_used;

    // Running start offsets: each column begins where the previous ends.
    always_comb begin
        start_o[0] = '0;
        for (int r = 1; r < P_RANK; r++) begin
            start_o[r] = start_o[r-1] + P_SW'(len_i[r-1]);
        end
    end

    // Total bit count and maximum weighted total of the shape.
    always_comb begin
        bits_used   = '0;
        weight_used = '0;
        for (int r = 0; r < P_RANK; r++) begin
            bits_used   = bits_used + P_BIG_W'(len_i[r]);
            weight_used = weight_used + (P_BIG_W'(len_i[r]) << r);
        end
    end

    // Shape is usable only inside both limits and with a nonzero width.
    always_comb begin
        legal_o = (bits_used <= P_BIG_W'(P_N_IN)) &&
                  (weight_used <= P_BIG_W'(P_MAXW)) &&
                  (width_i != '0);
    end
endmodule

// File: rtl/gpc_rank_select.sv
// Module: gpc_rank_select
// Picks the data bits that belong to one column (a window of len bits
// starting at start) and counts the ones among them. Assumes the window
// may run past the top data bit; positions beyond it simply do not exist.
module gpc_rank_select
    import gpc_pkg::*;
#(
    parameter int P_N_IN = N_IN,
    parameter int P_KW   = KW,
    parameter int P_SW   = SW
) (
    input  logic [P_N_IN-1:0] data_i,
    input  logic [P_SW-1:0]   start_i,
    input  logic [P_KW-1:0]   len_i,
    output logic [P_KW-1:0]   ones_o
);
    logic [P_N_IN-1:0] window;
    logic [P_SW-1:0]   stop;

    // Exclusive upper bound of the column window.
    always_comb stop = start_i + P_SW'(len_i);

    // Per-position membership of the window.
    always_comb begin
        for (int i = 0; i < P_N_IN; i++) begin
            window[i] = (P_SW'(i) >= start_i) && (P_SW'(i) < stop);
        end
    end

    // Population count of the selected bits.
    always_comb begin
        ones_o = '0;
        for (int i = 0; i < P_N_IN; i++) begin
            ones_o = ones_o + P_KW'(data_i[i] & window[i]);
        end
    end
endmodule

// File: rtl/gpc_out_format.sv
// Module: gpc_out_format
// Weights the column counts, forms the total, and lays out the result
// port in added or carry-save form. Assumes the top column is the carry
// half in carry-save form and that a legal shape keeps the total within
// P_CNT_W bits.
module gpc_out_format
    import gpc_pkg::*;
#(
    parameter int P_RANK   = N_RANK,
    parameter int P_KW     = KW,
    parameter int P_CNT_W  = CNT_W,
    parameter int P_HALF_W = HALF_W,
    parameter int P_RES_W  = RES_W,
    parameter int P_WSEL_W = WSEL_W
) (
    input  logic [P_RANK-1:0][P_KW-1:0] ones_i,
    input  logic [P_WSEL_W-1:0]         width_i,
    input  logic                        bypass_i,
    input  logic                        legal_i,
    output logic [P_CNT_W-1:0]          count_o,
    output logic [P_RES_W-1:0]          result_o
);
    logic [P_CNT_W-1:0]  sum_vec;
    logic [P_CNT_W-1:0]  carry_vec;
    logic [P_CNT_W-1:0]  total;
    logic [P_HALF_W-1:0] keep;

    // Lower columns form the sum half; the top column forms the carry half.
    always_comb begin
        sum_vec = '0;
        for (int r = 0; r < P_RANK - 1; r++) begin
            sum_vec = sum_vec + (P_CNT_W'(ones_i[r]) << r);
        end
        carry_vec = P_CNT_W'(ones_i[P_RANK-1]) << (P_RANK - 1);
        total     = sum_vec + carry_vec;
    end

    // Keep mask for the selected number of bits per half.
    always_comb begin
        for (int b = 0; b < P_HALF_W; b++) begin
            keep[b] = (P_WSEL_W'(b) < width_i);
        end
    end

    // Output selection; an illegal shape forces everything to zero.
    always_comb begin
        count_o  = '0;
        result_o = '0;
        if (legal_i) begin
            count_o = total;
            if (bypass_i) begin
                result_o = {carry_vec[P_HALF_W-1:0] & keep,
                            sum_vec[P_HALF_W-1:0] & keep};
            end else begin
                result_o = {{P_HALF_W{1'b0}}, total[P_HALF_W-1:0] & keep};
            end
        end
    end
endmodule

// File: rtl/gpc_counter_slice.sv
// Module: gpc_counter_slice
// Programmable generalized parallel counter for three adjacent columns,
// with an optional added or carry-save result and one register stage.
// Assumes a synchronous active-low reset and inputs that are stable
// around the rising edge.
module gpc_counter_slice
    import gpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   data_i,
    input  logic [KW-1:0]     len0_i,
    input  logic [KW-1:0]     len1_i,
    input  logic [KW-1:0]     len2_i,
    input  logic [WSEL_W-1:0] width_i,
    input  logic              bypass_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [RES_W-1:0]  result_o,
    output logic              cfg_err_o
);
    logic [N_RANK-1:0][KW-1:0] len_vec;
    logic [N_RANK-1:0][SW-1:0] start_vec;
    logic [N_RANK-1:0][KW-1:0] ones_vec;
    logic                      cfg_legal;
    logic [CNT_W-1:0]          count_d;
    logic [RES_W-1:0]          result_d;

    // Gather the per-column lengths into one vector.
    always_comb len_vec = {len2_i, len1_i, len0_i};

    gpc_cfg_check u_cfg (
        .len_i   (len_vec),
        .width_i (width_i),
        .start_o (start_vec),
        .legal_o (cfg_legal)
    );

    for (genvar r = 0; r < N_RANK; r++) begin : g_rank
        gpc_rank_select u_sel (
            .data_i  (data_i),
            .start_i (start_vec[r]),
            .len_i   (len_vec[r]),
            .ones_o  (ones_vec[r])
        );

        // A column never counts more ones than its configured length.
        AST_RANK_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
            ones_vec[r] <= len_vec[r]); // R3
    end

    gpc_out_format u_fmt (
        .ones_i   (ones_vec),
        .width_i  (width_i),
        .bypass_i (bypass_i),
        .legal_i  (cfg_legal),
        .count_o  (count_d),
        .result_o (result_d)
    );

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o   <= '0;
            result_o  <= '0;
            cfg_err_o <= 1'b0;
        end else begin
            count_o   <= count_d;
            result_o  <= result_d;
            cfg_err_o <= !cfg_legal;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && result_o == '0 && !cfg_err_o)); // R1

    AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (count_o == '0 && result_o == '0)); // R4

    AST_ADDED_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_legal && !bypass_i) |=> (result_o[RES_W-1:HALF_W] == '0)); // R6

    AST_ADDED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_legal && !bypass_i && width_i == 2'd3)
        |=> (result_o[HALF_W-1:0] == count_o[HALF_W-1:0])); // R6

    AST_CARRY_SAVE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_legal && bypass_i && width_i == 2'd3)
        |=> (HALF_W'(result_o[HALF_W-1:0] + result_o[RES_W-1:HALF_W])
             == count_o[HALF_W-1:0])); // R7
endmodule

// File: tb/gpc_counter_slice_tb_top.sv
`timescale 1ns/1ps
module gpc_counter_slice_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] data_i = '0;
    logic [4:0]  len0_i = '0, len1_i = '0, len2_i = '0;
    logic [1:0]  width_i = 2'd1;
    logic        bypass_i = 1'b0;
    logic [4:0]  count_o;
    logic [5:0]  result_o;
    logic        cfg_err_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct { int cnt; int res; int err; string tag; bit byp; } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    gpc_counter_slice dut_i (
        .clk(clk), .rst_n(rst_n), .data_i(data_i),
        .len0_i(len0_i), .len1_i(len1_i), .len2_i(len2_i),
        .width_i(width_i), .bypass_i(bypass_i),
        .count_o(count_o), .result_o(result_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
    endtask

    // Behavioural model: drive one cycle at a falling edge, check at the next.
    task automatic step(input logic [15:0] d, input int k0, input int k1, input int k2,
                        input int w, input bit byp, input string tag);
        exp_t e;
        int p0 = 0, p1 = 0, p2 = 0, m;
        bit legal;
        data_i = d; len0_i = 5'(k0); len1_i = 5'(k1); len2_i = 5'(k2);
        width_i = 2'(w); bypass_i = byp;
        for (int i = 0; i < 16; i++) begin
            if (i < k0) p0 += d[i];
            else if (i < k0 + k1) p1 += d[i];
            else if (i < k0 + k1 + k2) p2 += d[i];
        end
        legal = (k0 + k1 + k2 <= 16) && (k0 + 2*k1 + 4*k2 <= 31) && (w != 0);
        m = 1 << w;
        e.tag = tag; e.byp = byp;
        if (!legal) begin
            e.cnt = 0; e.res = 0; e.err = 1;
        end else begin
            e.cnt = p0 + 2*p1 + 4*p2; e.err = 0;
            if (byp) e.res = ((p0 + 2*p1) % m) | (((4*p2) % m) << 3);
            else     e.res = e.cnt % m;
        end
        exp_q.push_back(e);
        @(negedge clk);
        e = exp_q.pop_front();
        check(e.tag, "count_o", int'(count_o), e.cnt);
        check(e.byp ? "R7" : "R6", "result_o", int'(result_o), e.res);
        check("R4", "cfg_err_o", int'(cfg_err_o), e.err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        // R1: outputs clear while in reset, even with busy inputs.
        data_i = 16'hFFFF; len0_i = 5'd8; len1_i = 5'd4;
        repeat (3) @(negedge clk);
        check("R1", "count_o", int'(count_o), 0);
        check("R1", "result_o", int'(result_o), 0);
        check("R1", "cfg_err_o", int'(cfg_err_o), 0);
        rst_n = 1'b1;

        // R5: largest legal shape, all used bits set.
        step(16'h0FFF, 3, 4, 5, 3, 0, "R5");
        step(16'h0FFF, 3, 4, 5, 3, 1, "R5");
        // R3: every unused position set, used positions clear.
        step(16'hFFF8, 3, 0, 0, 2, 0, "R3");
        step(16'hFF00, 2, 1, 1, 3, 1, "R3");
        step(16'h8000, 15, 0, 0, 3, 0, "R3");
        // R8: same data, bypass and width changed.
        step(16'hA5A5, 4, 3, 2, 3, 0, "R8");
        step(16'hA5A5, 4, 3, 2, 3, 1, "R8");
        step(16'hA5A5, 4, 3, 2, 1, 1, "R8");
        // R4: just past each limit, and zero width.
        step(16'hFFFF, 16, 1, 0, 3, 0, "R4");
        step(16'hFFFF, 0, 0, 8, 3, 0, "R4");
        step(16'hFFFF, 1, 1, 7, 3, 1, "R4");
        step(16'hFFFF, 3, 4, 5, 0, 0, "R4");
        step(16'hFFFF, 16, 0, 0, 3, 0, "R4");
        // R2: sweep every legal shape with random data and modes.
        for (int k2 = 0; k2 <= 7; k2++) begin
            for (int k1 = 0; k1 <= 15; k1++) begin
                for (int k0 = 0; k0 <= 16; k0++) begin
                    if (k0 + k1 + k2 <= 16 && k0 + 2*k1 + 4*k2 <= 31) begin
                        for (int n = 0; n < 2; n++) begin
                            step(16'($urandom), k0, k1, k2,
                                 1 + int'($urandom % 3), 1'($urandom), "R2");
                        end
                    end
                end
            end
        end
        summary();
        $finish;
    end
endmodule